// File: doc/BRIEF.md
# Multivalued-Guard Table-Driven State Sequencer

This block runs one state machine whose transition guards are written over multivalued inputs instead of single Boolean wires. Each input group presents exactly one active value as a one-hot code, and the top value of every group is reserved to mean "unknown", for example when a sensor cable is broken. The engine joins these codes behind a constant-true bit to form a virtual input vector. Every guard is a sum of product terms. Each product term is a stored bit mask, and it holds when all of its set bits are also set in the vector.

The transition table is loaded through an address, data and write-enable port while the engine is held in reset. Each table entry holds a per-state transition header (a valid flag and a target state) and a set of term masks. Once reset is released, an accepted input sample is evaluated against the current state's transitions. The engine then issues single-cycle action strobes in a fixed order: input, exit, transition, entry. Action bodies live outside the block, and these strobes tell them when to run.

Top module: `mvfsm_engine`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cur_state` is 0, `busy` is low and all four strobes are low.
- R2: A table write happens only when `cfg_we` and `rst` are both high. `cfg_addr` is {state, transition, term}, with the term index in the low bits. `cfg_hdr`=0 writes `cfg_data` as a term mask. `cfg_hdr`=1 writes a header whose bit 3 is valid and bits 2:0 are the target. A write with `rst` low changes nothing.
- R3: In the virtual input vector, bit 0 is always 1, and value v of group g sits at bit 1+4g+v. Value 3 of each group is the unknown code. A term whose mask is only bit 0 is always satisfied.
- R4: A term is satisfied when its mask is nonzero and has no bit outside the vector. A mask of zero is never satisfied. A transition holds when its header is valid and any of its terms is satisfied. Negating a value is written as one term per remaining value of that group.
- R5: A transition whose header valid bit is 0 never fires, whatever its terms hold.
- R6: When several transitions of the current state hold, the lowest index is taken.
- R7: `in_valid` is accepted at a clock edge where `busy` is low. `busy` is high in the next cycle, and `stb_input` pulses in the cycle after that.
- R8: On a taken transition, `stb_exit`, `stb_trans` and `stb_entry` follow `stb_input` on the three consecutive cycles. `cur_state` takes the target in the `stb_entry` cycle, where `busy` is already low.
- R9: When no transition holds, only `stb_input` pulses. `busy` is low in that same cycle, and `cur_state` is unchanged.
- R10: `in_valid` raised while `busy` is high is ignored and starts no further sequence.
- R11: `act_from`, `act_to` and `act_idx` are set with `stb_input` and held through `stb_entry`. On a miss, `act_to` equals the current state and `act_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also opens the table write port |
| cfg_we | input | 1 | Table write enable |
| cfg_hdr | input | 1 | 1 selects the transition header, 0 selects a term mask |
| cfg_addr | input | 7 | {state, transition, term} |
| cfg_data | input | 13 | Term mask or header word |
| in_valid | input | 1 | New input sample present |
| in_codes | input | 12 | Three 4-bit one-hot group codes, group 0 in the low bits |
| busy | output | 1 | Sequence in progress |
| cur_state | output | 3 | Current state |
| stb_input | output | 1 | Input action strobe |
| stb_exit | output | 1 | Exit action strobe of the old state |
| stb_trans | output | 1 | Transition action strobe |
| stb_entry | output | 1 | Entry action strobe of the new state |
| act_from | output | 3 | State being evaluated |
| act_to | output | 3 | Target state, or the current state on a miss |
| act_idx | output | 2 | Index of the taken transition |

## Verification
The assertions assume that every group code is exactly one-hot whenever a sample can be accepted. This means `in_valid` is high while `busy` is low, and any other code pattern is outside the contract. The stimulus builds every code by shifting a single 1 into each 4-bit group, including the unknown value. It also keeps codes one-hot when it raises `in_valid` during a busy sequence. All table writes are made during reset, and every header and mask is cleared first, so no guard ever reads unwritten storage.

// File: rtl/mvfsm_pkg.sv
package mvfsm_pkg;

  typedef enum logic [2:0] {
    CTL_IDLE  = 3'd0,
    CTL_EVAL  = 3'd1,
    CTL_EXIT  = 3'd2,
    CTL_TRANS = 3'd3,
    CTL_ENTRY = 3'd4
  } ctl_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mvfsm_table.sv
module mvfsm_table #(
  parameter int N_STATES = 8,
  parameter int N_TRANS  = 4,
  parameter int N_TERMS  = 4,
  parameter int VI_W     = 13,
  parameter int ST_W     = 3,
  parameter int TR_W     = 2,
  parameter int TM_W     = 2
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic                          wr_hdr,
  input  logic [ST_W+TR_W+TM_W-1:0]     wr_addr,
  input  logic [VI_W-1:0]               wr_data,
  input  logic [ST_W-1:0]               rd_state,
  output logic [N_TRANS*N_TERMS*VI_W-1:0] masks,
  output logic [N_TRANS-1:0]            hdr_valid,
  output logic [N_TRANS*ST_W-1:0]       hdr_dst
);

  localparam int AW = ST_W + TR_W + TM_W;

  logic [ST_W-1:0] wr_state;
  logic [TR_W-1:0] wr_trans;
  logic [TM_W-1:0] wr_term;

  assign wr_state = wr_addr[AW-1 -: ST_W];
  assign wr_trans = wr_addr[TM_W +: TR_W];
  assign wr_term  = wr_addr[TM_W-1:0];

  for (genvar t = 0; t < N_TRANS; t++) begin : g_tr
    logic [ST_W:0] hdr_mem [N_STATES];
    logic [ST_W:0] hdr_rd;

    always_ff @(posedge clk) begin
      if (wr_en && wr_hdr && (wr_trans == TR_W'(t)))
        hdr_mem[wr_state] <= wr_data[ST_W:0];
      hdr_rd <= hdr_mem[rd_state];
    end

    assign hdr_valid[t]             = hdr_rd[ST_W];
    assign hdr_dst[t*ST_W +: ST_W]  = hdr_rd[ST_W-1:0];

    for (genvar k = 0; k < N_TERMS; k++) begin : g_tm
      logic [VI_W-1:0] term_mem [N_STATES];
      logic [VI_W-1:0] term_rd;

      always_ff @(posedge clk) begin
        if (wr_en && !wr_hdr && (wr_trans == TR_W'(t)) && (wr_term == TM_W'(k)))
          term_mem[wr_state] <= wr_data;
        term_rd <= term_mem[rd_state];
      end

      assign masks[(t*N_TERMS+k)*VI_W +: VI_W] = term_rd;
    end
  end

endmodule

// File: rtl/mvfsm_guard.sv
module mvfsm_guard #(
  parameter int N_TRANS = 4,
  parameter int N_TERMS = 4,
  parameter int VI_W    = 13,
  parameter int ST_W    = 3,
  parameter int TR_W    = 2
) (
  input  logic [VI_W-1:0]                 vi,
  input  logic [N_TRANS*N_TERMS*VI_W-1:0] masks,
  input  logic [N_TRANS-1:0]              hdr_valid,
  input  logic [N_TRANS*ST_W-1:0]         hdr_dst,
  output logic                            hit,
  output logic [TR_W-1:0]                 idx,
  output logic [ST_W-1:0]                 dst
);

  logic [N_TRANS-1:0] tr_ok;

  for (genvar t = 0; t < N_TRANS; t++) begin : g_tr
    logic [N_TERMS-1:0] term_ok;
    for (genvar k = 0; k < N_TERMS; k++) begin : g_tm
      logic [VI_W-1:0] m;
      assign m          = masks[(t*N_TERMS+k)*VI_W +: VI_W];
      assign term_ok[k] = (|m) && ((m & ~vi) == '0);
    end
    assign tr_ok[t] = hdr_valid[t] && (|term_ok);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    dst = '0;
    for (int t = N_TRANS-1; t >= 0; t--) begin
      if (tr_ok[t]) begin
        hit = 1'b1;
        idx = TR_W'(t);
        dst = hdr_dst[t*ST_W +: ST_W];
      end
    end
  end

endmodule

// File: rtl/mvfsm_seq.sv
module mvfsm_seq
  import mvfsm_pkg::*;
#(
  parameter int VI_W = 13,
  parameter int ST_W = 3,
  parameter int TR_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [VI_W-1:0] vi_in,
  input  logic            hit,
  input  logic [TR_W-1:0] hit_idx,
  input  logic [ST_W-1:0] hit_dst,
  output logic [VI_W-1:0] vi_q,
  output logic [ST_W-1:0] cur,
  output logic            busy,
  output logic            s_input,
  output logic            s_exit,
  output logic            s_trans,
  output logic            s_entry,
  output logic [ST_W-1:0] a_from,
  output logic [ST_W-1:0] a_to,
  output logic [TR_W-1:0] a_idx
);

  ctl_e ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl     <= CTL_IDLE;
      busy    <= 1'b0;
      vi_q    <= '0;
      cur     <= '0;
      s_input <= 1'b0;
      s_exit  <= 1'b0;
      s_trans <= 1'b0;
      s_entry <= 1'b0;
      a_from  <= '0;
      a_to    <= '0;
      a_idx   <= '0;
    end else begin
      s_input <= 1'b0;
      s_exit  <= 1'b0;
      s_trans <= 1'b0;
      s_entry <= 1'b0;
      case (ctl)
        CTL_IDLE: begin
          if (in_valid) begin
            vi_q <= vi_in;
            ctl  <= CTL_EVAL;
            busy <= 1'b1;
          end
        end
        CTL_EVAL: begin
          s_input <= 1'b1;
          a_from  <= cur;
          a_to    <= hit ? hit_dst : cur;
          a_idx   <= hit ? hit_idx : '0;
          busy    <= hit;
          ctl     <= hit ? CTL_EXIT : CTL_IDLE;
        end
        CTL_EXIT: begin
          s_exit <= 1'b1;
          ctl    <= CTL_TRANS;
        end
        CTL_TRANS: begin
          s_trans <= 1'b1;
          ctl     <= CTL_ENTRY;
        end
        CTL_ENTRY: begin
          s_entry <= 1'b1;
          cur     <= a_to;
          busy    <= 1'b0;
          ctl     <= CTL_IDLE;
        end
        default: begin
          ctl  <= CTL_IDLE;
          busy <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/mvfsm_engine.sv
module mvfsm_engine
  import mvfsm_pkg::*;
#(
  parameter int N_STATES = 8,
  parameter int N_TRANS  = 4,
  parameter int N_TERMS  = 4,
  parameter int N_GRP    = 3,
  parameter int GRP_W    = 4,
  localparam int ST_W    = idx_bits(N_STATES),
  localparam int TR_W    = idx_bits(N_TRANS),
  localparam int TM_W    = idx_bits(N_TERMS),
  localparam int IN_W    = N_GRP * GRP_W,
  localparam int VI_W    = IN_W + 1,
  localparam int AW      = ST_W + TR_W + TM_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic            cfg_hdr,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [VI_W-1:0] cfg_data,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_codes,
  output logic            busy,
  output logic [ST_W-1:0] cur_state,
  output logic            stb_input,
  output logic            stb_exit,
  output logic            stb_trans,
  output logic            stb_entry,
  output logic [ST_W-1:0] act_from,
  output logic [ST_W-1:0] act_to,
  output logic [TR_W-1:0] act_idx
);

  logic                            wr_go;
  logic [VI_W-1:0]                 vi_now;
  logic [VI_W-1:0]                 vi_held;
  logic [N_TRANS*N_TERMS*VI_W-1:0] masks;
  logic [N_TRANS-1:0]              hdr_valid;
  logic [N_TRANS*ST_W-1:0]         hdr_dst;
  logic                            g_hit;
  logic [TR_W-1:0]                 g_idx;
  logic [ST_W-1:0]                 g_dst;

  assign wr_go  = cfg_we & rst;
  assign vi_now = {in_codes, 1'b1};

  mvfsm_table #(
    .N_STATES(N_STATES), .N_TRANS(N_TRANS), .N_TERMS(N_TERMS),
    .VI_W(VI_W), .ST_W(ST_W), .TR_W(TR_W), .TM_W(TM_W)
  ) u_table (
    .clk      (clk),
    .wr_en    (wr_go),
    .wr_hdr   (cfg_hdr),
    .wr_addr  (cfg_addr),
    .wr_data  (cfg_data),
    .rd_state (cur_state),
    .masks    (masks),
    .hdr_valid(hdr_valid),
    .hdr_dst  (hdr_dst)
  );

  mvfsm_guard #(
    .N_TRANS(N_TRANS), .N_TERMS(N_TERMS), .VI_W(VI_W), .ST_W(ST_W), .TR_W(TR_W)
  ) u_guard (
    .vi       (vi_held),
    .masks    (masks),
    .hdr_valid(hdr_valid),
    .hdr_dst  (hdr_dst),
    .hit      (g_hit),
    .idx      (g_idx),
    .dst      (g_dst)
  );

  mvfsm_seq #(
    .VI_W(VI_W), .ST_W(ST_W), .TR_W(TR_W)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .in_valid(in_valid),
    .vi_in   (vi_now),
    .hit     (g_hit),
    .hit_idx (g_idx),
    .hit_dst (g_dst),
    .vi_q    (vi_held),
    .cur     (cur_state),
    .busy    (busy),
    .s_input (stb_input),
    .s_exit  (stb_exit),
    .s_trans (stb_trans),
    .s_entry (stb_entry),
    .a_from  (act_from),
    .a_to    (act_to),
    .a_idx   (act_idx)
  );

endmodule

// File: rtl/mvfsm_engine_chk.sv
module mvfsm_engine_chk #(
  parameter int N_GRP = 3,
  parameter int GRP_W = 4,
  parameter int ST_W  = 3,
  parameter int TR_W  = 2
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [N_GRP*GRP_W-1:0] in_codes,
  input logic                   busy,
  input logic [ST_W-1:0]        cur_state,
  input logic                   stb_input,
  input logic                   stb_exit,
  input logic                   stb_trans,
  input logic                   stb_entry,
  input logic [ST_W-1:0]        act_to,
  input logic [TR_W-1:0]        act_idx
);

  // R8: strobes are mutually exclusive
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb_input, stb_exit, stb_trans, stb_entry}))
    else $error("strobes overlap");

  p_exit_after_input_r8: assert property (@(posedge clk) disable iff (rst)
    stb_exit |-> $past(stb_input))
    else $error("exit not preceded by input strobe");

  p_trans_after_exit_r8: assert property (@(posedge clk) disable iff (rst)
    stb_trans |-> $past(stb_exit))
    else $error("transition not preceded by exit strobe");

  p_entry_after_trans_r8: assert property (@(posedge clk) disable iff (rst)
    stb_entry |-> ($past(stb_trans) && !busy))
    else $error("entry strobe out of order or busy still high");

  // R9: state only moves together with the entry strobe
  p_state_moves_on_entry_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_state) |-> stb_entry)
    else $error("state changed without entry strobe");

  // R11: action descriptors held during the sequence
  p_hold_action_r11: assert property (@(posedge clk) disable iff (rst)
    (stb_exit || stb_trans || stb_entry) |-> ($stable(act_to) && $stable(act_idx)))
    else $error("action descriptor changed mid-sequence");

  // R3: each group code is one-hot when a sample can be accepted
  for (genvar g = 0; g < N_GRP; g++) begin : g_in
    p_group_onehot_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !busy) |-> $onehot(in_codes[g*GRP_W +: GRP_W]))
      else $error("group code not one-hot");
  end

endmodule

bind mvfsm_engine mvfsm_engine_chk #(
  .N_GRP(N_GRP), .GRP_W(GRP_W), .ST_W(ST_W), .TR_W(TR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_codes (in_codes),
  .busy     (busy),
  .cur_state(cur_state),
  .stb_input(stb_input),
  .stb_exit (stb_exit),
  .stb_trans(stb_trans),
  .stb_entry(stb_entry),
  .act_to   (act_to),
  .act_idx  (act_idx)
);

// File: tb/sim_mvfsm_engine.sv
`timescale 1ns/1ps
module sim_mvfsm_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_hdr = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [12:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [11:0] in_codes = 12'h111;
  logic        busy;
  logic [2:0]  cur_state;
  logic        stb_input, stb_exit, stb_trans, stb_entry;
  logic [2:0]  act_from, act_to;
  logic [1:0]  act_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [2:0] model_state;

  always #4 clk = ~clk;

  mvfsm_engine u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_hdr(cfg_hdr),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_codes(in_codes),
    .busy(busy), .cur_state(cur_state),
    .stb_input(stb_input), .stb_exit(stb_exit),
    .stb_trans(stb_trans), .stb_entry(stb_entry),
    .act_from(act_from), .act_to(act_to), .act_idx(act_idx)
  );

  function automatic logic [11:0] cd(input int a, input int b, input int c);
    return {4'(1 << c), 4'(1 << b), 4'(1 << a)};
  endfunction

  function automatic logic [12:0] vb(input int g, input int v);
    return 13'(1) << (1 + g*4 + v);
  endfunction

  // {codes[11:0], hit, dst[2:0], idx[1:0]}
  localparam int NV = 11;
  localparam logic [17:0] VEC [NV] = '{
    {cd(1,1,0), 1'b0, 3'd0, 2'd0},
    {cd(2,1,0), 1'b1, 3'd1, 2'd0},
    {cd(0,0,0), 1'b1, 3'd2, 2'd0},
    {cd(1,1,0), 1'b0, 3'd2, 2'd0},
    {cd(1,2,0), 1'b1, 3'd0, 2'd0},
    {cd(3,0,0), 1'b1, 3'd3, 2'd1},
    {cd(0,0,0), 1'b0, 3'd3, 2'd0},
    {cd(0,0,1), 1'b1, 3'd0, 2'd0},
    {cd(2,0,0), 1'b0, 3'd0, 2'd0},
    {cd(2,1,0), 1'b1, 3'd1, 2'd0},
    {cd(1,0,0), 1'b1, 3'd0, 2'd1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit hdr, input int s, input int t, input int k, input logic [12:0] d);
    @(negedge clk);
    cfg_we   = 1'b1;
    cfg_hdr  = hdr;
    cfg_addr = {3'(s), 2'(t), 2'(k)};
    cfg_data = d;
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  function automatic logic [12:0] hw(input bit v, input int dst);
    return {9'd0, v, 3'(dst)};
  endfunction

  task automatic step(input logic [11:0] codes, input bit hit, input logic [2:0] dst,
                      input logic [1:0] idx, input bit poke);
    logic [2:0] from;
    from = model_state;
    @(negedge clk);
    in_valid = 1'b1;
    in_codes = codes;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 busy after accept", busy, 1);
    chk("R7 no input strobe yet", stb_input, 0);
    @(negedge clk);
    chk("R7 input strobe", stb_input, 1);
    chk("R11 act_from", act_from, from);
    chk("R11 act_to", act_to, hit ? dst : from);
    chk("R6 act_idx", act_idx, hit ? idx : 2'd0);
    chk("R9 busy with input strobe", busy, hit);
    if (poke) begin
      in_valid = 1'b1;
      in_codes = cd(0, 0, 0);
    end
    if (hit) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk("R8 exit strobe", {stb_input, stb_exit, stb_trans, stb_entry}, 4'b0100);
      chk("R8 busy during exit", busy, 1);
      @(negedge clk);
      chk("R8 transition strobe", {stb_input, stb_exit, stb_trans, stb_entry}, 4'b0010);
      @(negedge clk);
      chk("R8 entry strobe", {stb_input, stb_exit, stb_trans, stb_entry}, 4'b0001);
      chk("R8 busy low at entry", busy, 0);
      chk("R8 state at entry", cur_state, dst);
      chk("R11 act_to held", act_to, dst);
      model_state = dst;
    end else begin
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 no further strobes", {stb_input, stb_exit, stb_trans, stb_entry}, 4'b0000);
      chk("R9 state kept", cur_state, from);
    end
    if (poke) begin
      @(negedge clk);
      chk("R10 no restart busy", busy, 0);
      @(negedge clk);
      chk("R10 no restart strobe", stb_input, 0);
      chk("R10 state unchanged", cur_state, model_state);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    model_state = 3'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset state", cur_state, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset strobes", {stb_input, stb_exit, stb_trans, stb_entry}, 4'b0000);

    // R2: load while in reset, clearing every entry first
    for (int s = 0; s < 8; s++)
      for (int t = 0; t < 4; t++) begin
        wr(1'b1, s, t, 0, 13'd0);
        for (int k = 0; k < 4; k++) wr(1'b0, s, t, k, 13'd0);
      end
    wr(1'b1, 0, 0, 0, hw(1, 1)); wr(1'b0, 0, 0, 0, vb(0,2) | vb(1,1));
    wr(1'b1, 0, 1, 0, hw(1, 3)); wr(1'b0, 0, 1, 0, vb(0,3));
    wr(1'b1, 1, 0, 0, hw(1, 2)); wr(1'b0, 1, 0, 0, vb(0,0));
    wr(1'b1, 1, 1, 0, hw(1, 0)); wr(1'b0, 1, 1, 0, 13'd1);   // R3 always term
    wr(1'b1, 2, 0, 0, hw(1, 0)); wr(1'b0, 2, 0, 0, vb(1,0));
    wr(1'b0, 2, 0, 1, vb(1,2));                               // R4 complement of B1
    wr(1'b1, 2, 1, 0, hw(0, 5)); wr(1'b0, 2, 1, 0, 13'd1);   // R5 invalid header
    wr(1'b1, 2, 2, 0, hw(1, 7));                              // R4 zero masks only
    wr(1'b1, 3, 0, 0, hw(1, 0)); wr(1'b0, 3, 0, 0, vb(0,0) | vb(2,1));

    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release state", cur_state, 0);
    chk("R1 after release busy", busy, 0);

    // table walk: R3 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++)
      step(VEC[i][17:6], VEC[i][5], VEC[i][4:2], VEC[i][1:0], 1'b0);

    // R2: write with reset low is ignored
    wr(1'b1, 0, 2, 0, hw(1, 6));
    wr(1'b0, 0, 2, 0, 13'd1);
    step(cd(1, 0, 0), 1'b0, 3'd0, 2'd0, 1'b0);

    // R10: input raised during busy is dropped
    step(cd(2, 1, 0), 1'b1, 3'd1, 2'd0, 1'b1);

    // R1: reset returns to state 0
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset again state", cur_state, 0);
    chk("R1 reset again busy", busy, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule